// File: doc/BRIEF.md
# Erasable PROM Burn-and-Verify Sequencer

This block sits on the host side of an ultraviolet-erasable PROM. It writes a run of bytes into the PROM and reads each one back to confirm it. A single-cycle start command supplies a base address, a word count and a pulse profile. The bytes then arrive one at a time over a valid/ready handshake. For every byte the sequencer drives the PROM address and data lines, the data-bus driver enable, the programming-supply enable, the output-enable level and the chip-enable pulse in a fixed order. Each interval lasts a whole number of clock cycles. That number is derived at elaboration time from a clock-frequency parameter and a minimum time in nanoseconds, and it is rounded up so that no minimum is ever cut short.

Two pulse profiles are offered. The single-pulse profile (mode_i = 0) applies one long chip-enable pulse per address. If the read-back does not match, the run fails. The incremental profile (mode_i = 1) applies short pulses, with a read-back after each one, up to a retry limit. Once the byte reads back correctly, it applies one over-program pulse. That pulse is OVP_MULT times as long as all the short pulses the byte needed. A byte of all ones is already in the erased state, so it gets no pulse, but it is still read back.

The controller is a single state machine with these states:
- S_IDLE: waiting for a command.
- S_FETCH: accepting a byte.
- S_SETUP: the programming supply is on and the address and data are held before the pulse.
- S_PULSE: the short or long pulse.
- S_OVP: the over-program pulse.
- S_HOLD: lines are held after a pulse.
- S_RELEASE: the driver and supply are off before the read.
- S_READ: chip enable and output enable are low.
- S_RECOVER: the bus is released after the read.
- S_NEXT: the address advances.
- S_FINISH: the run ends.

The transitions are:
- From S_IDLE: to S_FETCH on start, or to S_FINISH when the count is zero.
- From S_FETCH: to S_SETUP, or to S_RELEASE for an all-ones byte.
- From S_SETUP: to S_PULSE, or to S_OVP once the byte has passed.
- From S_PULSE or S_OVP: to S_HOLD.
- From S_HOLD: to S_RELEASE, or to S_NEXT after an over-program pulse.
- From S_RELEASE: to S_READ.
- From S_READ: to S_RECOVER.
- From S_RECOVER:
  - to S_SETUP to retry, or to over-program after a pass in the incremental profile;
  - to S_NEXT on a pass in the single-pulse profile, or for an all-ones byte;
  - to S_FINISH on a failure.
- From S_NEXT: to S_FETCH, or to S_FINISH after the last word.
- From S_FINISH: to S_IDLE.

Top module: `eprom_burn_seq`

## Requirements
- R1: After reset the PROM pins are inactive: chip enable high, output enable high, supply enable low, driver off. wr_ready_o, busy_o, done_o and fail_o are all 0.
- R2: Each word takes exactly one byte over the valid/ready handshake, and wr_ready_o is high only while a byte is awaited. Word i goes to address (base + i) modulo 2^AW.
- R3: Before a pulse, the address, the write data, the driver enable and the supply enable are all steady, with chip enable high, for at least the setup cycle count. A pulse drives chip enable low while output enable is high and the supply is on.
- R4: With mode_i = 0, each word that is not all ones receives exactly one pulse of the long cycle count. A read-back mismatch ends the run as failed.
- R5: With mode_i = 1, pulses of the short cycle count are repeated, with a read-back after each. This continues until the byte matches or the retry limit MAX_TRIES is reached; reaching the limit without a match fails the run.
- R6: With mode_i = 1, after a byte that needed n pulses matches, exactly one over-program pulse of OVP_MULT × n × short cycles follows. The sequencer then moves to the next word with no further read-back.
- R7: After a pulse ends, the address, the write data and the supply enable stay steady for at least the hold cycle count.
- R8: The driver and the supply are off for at least the bus-release cycle count before output enable falls. The byte is sampled only after chip enable and output enable have been low for the read cycle count.
- R9: A byte of 8'hFF receives no pulse but is still read back. A read-back other than 8'hFF fails the run.
- R10: On failure the sequencer stops: fail_o = 1, fail_addr_o holds the failing address, no further bytes are taken and no further pulses are given.
- R11: When the run ends, done_o = 1 and busy_o = 0, and fail_o = 0 if every word passed. A count of zero finishes the run without taking any byte.
- R12: Every interval lasts ceil(time × CLK_HZ / 10^9) cycles, with a minimum of 1.
- R13: A start that arrives while the sequencer is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command (taken in S_IDLE only) |
| mode_i | input | 1 | 0: single long pulse; 1: short pulses with retry and over-program |
| base_addr_i | input | AW | First PROM address |
| word_count_i | input | AW+1 | Number of words (0 to 2^AW) |
| wr_valid_i | input | 1 | Byte available |
| wr_data_i | input | DW | Byte to write |
| wr_ready_o | output | 1 | Byte accepted when high together with wr_valid_i |
| prom_addr_o | output | AW | PROM address |
| prom_wdata_o | output | DW | Data driven onto the PROM bus |
| prom_wdrive_o | output | 1 | Bus driver enable |
| prom_din_i | input | DW | Data read from the PROM bus |
| prom_ce_n_o | output | 1 | Chip enable, active low |
| prom_oe_n_o | output | 1 | Output enable, active low |
| prom_vpp_en_o | output | 1 | Programming-supply enable |
| busy_o | output | 1 | Sequencer not idle |
| done_o | output | 1 | Run finished; cleared by the next start |
| fail_o | output | 1 | Run ended on a failed read-back |
| fail_addr_o | output | AW | Address that failed |

## Verification
The PROM pins are decoded from the state register. A pin therefore changes in the cycle after the edge that enters a state. An edge-triggered monitor sees that change one edge later, so it measures each pulse, setup, hold and release window as a count of observed cycles. For example, chip enable falls exactly the setup count after the supply comes on, and it stays low for exactly the pulse count. The PROM model returns the true byte only once the read has lasted the read count, counting the register on the sampling edge. A read-back sampled one cycle early therefore gives a mismatch. done_o rises one cycle after S_FINISH is entered, and the bench reads the result pins at falling edges only after it has seen done_o.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_SETUP,
        S_PULSE,
        S_OVP,
        S_HOLD,
        S_RELEASE,
        S_READ,
        S_RECOVER,
        S_NEXT,
        S_FINISH
    } seq_state_e;

    // Round a time in ns up to whole clock cycles, at least one.
    function automatic longint unsigned time_to_cycles(input longint unsigned ns,
                                                       input longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic longint unsigned max2(input longint unsigned a,
                                             input longint unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= load_val_i - TW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign expired_o = (cnt == '0);

    // R12: every interval is at least one cycle long
    a_r12_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (load_val_i != '0));

    // R12: a running interval counts down by one each cycle
    a_r12_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt != '0) |=> (cnt == $past(cnt) - TW'(1)));

endmodule

// File: rtl/word_walker.sv
module word_walker #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW:0]   count_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);
    logic [AW:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            rem    <= '0;
        end else if (init_i) begin
            addr_o <= base_i;
            rem    <= count_i;
        end else if (step_i) begin
            addr_o <= addr_o + AW'(1);
            rem    <= rem - (AW+1)'(1);
        end
    end

    assign last_o = (rem == (AW+1)'(1));

    // R2: the walker never advances past the requested word count
    a_r2_step_has_words: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (rem != '0));

endmodule

// File: rtl/vfy_compare.sv
module vfy_compare #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] probe_i,
    input  logic          sample_i,
    input  logic [DW-1:0] expect_i,
    input  logic [DW-1:0] read_i,
    output logic          skip_o,
    output logic          match_o
);
    assign skip_o = &probe_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_o <= 1'b0;
        end else if (sample_i) begin
            match_o <= (read_i == expect_i);
        end
    end

endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
    import eprom_seq_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          DW        = 8,
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned SETUP_NS  = 2_000,
    parameter int unsigned HOLD_NS   = 2_000,
    parameter int unsigned LONG_NS   = 50_000_000,
    parameter int unsigned SHORT_NS  = 1_000_000,
    parameter int unsigned VFY_NS    = 1_000,
    parameter int unsigned FLOAT_NS  = 130,
    parameter int          MAX_TRIES = 25,
    parameter int          OVP_MULT  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [AW:0]   word_count_i,
    input  logic          wr_valid_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          wr_ready_o,
    output logic [AW-1:0] prom_addr_o,
    output logic [DW-1:0] prom_wdata_o,
    output logic          prom_wdrive_o,
    input  logic [DW-1:0] prom_din_i,
    output logic          prom_ce_n_o,
    output logic          prom_oe_n_o,
    output logic          prom_vpp_en_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic [AW-1:0] fail_addr_o
);
    localparam longint unsigned SETUP_C = time_to_cycles(SETUP_NS, CLK_HZ);
    localparam longint unsigned HOLD_C  = time_to_cycles(HOLD_NS,  CLK_HZ);
    localparam longint unsigned LONG_C  = time_to_cycles(LONG_NS,  CLK_HZ);
    localparam longint unsigned SHORT_C = time_to_cycles(SHORT_NS, CLK_HZ);
    localparam longint unsigned VFY_C   = time_to_cycles(VFY_NS,   CLK_HZ);
    localparam longint unsigned FLOAT_C = time_to_cycles(FLOAT_NS, CLK_HZ);
    localparam longint unsigned MAXC    = max2(max2(max2(SETUP_C, HOLD_C), max2(LONG_C, SHORT_C)),
                                               max2(VFY_C, FLOAT_C));
    localparam int TW  = $clog2(MAXC + 1);
    localparam int TRW = $clog2(MAX_TRIES + 1);
    localparam int OVW = $clog2(MAX_TRIES * OVP_MULT + 1);

    seq_state_e     state, state_n;
    logic           mode_r, skip_r, ovp_phase;
    logic [DW-1:0]  data_r;
    logic [TRW-1:0] tries;
    logic [OVW-1:0] ovp_left;
    logic           done_r, fail_r;
    logic [AW-1:0]  fail_addr_r;

    logic           tmr_exp, tmr_load, ovp_rearm;
    logic [TW-1:0]  tmr_val;
    logic           walk_last, skip_in, vfy_match;
    logic           take_start, take_byte, fail_now;

    assign take_start = (state == S_IDLE) && start_i;
    assign take_byte  = (state == S_FETCH) && wr_valid_i;

    seq_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    word_walker #(.AW(AW)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (take_start),
        .base_i  (base_addr_i),
        .count_i (word_count_i),
        .step_i  (state == S_NEXT),
        .addr_o  (prom_addr_o),
        .last_o  (walk_last)
    );

    vfy_compare #(.DW(DW)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .probe_i  (wr_data_i),
        .sample_i ((state == S_READ) && tmr_exp),
        .expect_i (data_r),
        .read_i   (prom_din_i),
        .skip_o   (skip_in),
        .match_o  (vfy_match)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Next state
    always_comb begin
        state_n   = state;
        ovp_rearm = 1'b0;
        unique case (state)
            S_IDLE:    if (start_i) state_n = (word_count_i == '0) ? S_FINISH : S_FETCH;
            S_FETCH:   if (wr_valid_i) state_n = skip_in ? S_RELEASE : S_SETUP;
            S_SETUP:   if (tmr_exp) state_n = ovp_phase ? S_OVP : S_PULSE;
            S_PULSE:   if (tmr_exp) state_n = S_HOLD;
            S_OVP: begin
                if (tmr_exp) begin
                    if (ovp_left == OVW'(1)) state_n = S_HOLD;
                    else                     ovp_rearm = 1'b1;
                end
            end
            S_HOLD:    if (tmr_exp) state_n = ovp_phase ? S_NEXT : S_RELEASE;
            S_RELEASE: if (tmr_exp) state_n = S_READ;
            S_READ:    if (tmr_exp) state_n = S_RECOVER;
            S_RECOVER: begin
                if (tmr_exp) begin
                    if (vfy_match)
                        state_n = (mode_r && !skip_r) ? S_SETUP : S_NEXT;
                    else if (mode_r && !skip_r && tries < TRW'(MAX_TRIES))
                        state_n = S_SETUP;
                    else
                        state_n = S_FINISH;
                end
            end
            S_NEXT:    state_n = walk_last ? S_FINISH : S_FETCH;
            S_FINISH:  state_n = S_IDLE;
            default:   state_n = S_IDLE;
        endcase
    end

    assign fail_now = (state == S_RECOVER) && (state_n == S_FINISH);

    // Interval length for the state being entered
    always_comb begin
        unique case (state_n)
            S_SETUP:   tmr_val = TW'(SETUP_C);
            S_PULSE:   tmr_val = mode_r ? TW'(SHORT_C) : TW'(LONG_C);
            S_OVP:     tmr_val = TW'(SHORT_C);
            S_HOLD:    tmr_val = TW'(HOLD_C);
            S_RELEASE: tmr_val = TW'(FLOAT_C);
            S_READ:    tmr_val = TW'(VFY_C);
            S_RECOVER: tmr_val = TW'(FLOAT_C);
            default:   tmr_val = TW'(1);
        endcase
    end
    assign tmr_load = (state_n != state) || ovp_rearm;

    // Word context, retry and over-program bookkeeping, result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r      <= 1'b0;
            data_r      <= '0;
            skip_r      <= 1'b0;
            ovp_phase   <= 1'b0;
            tries       <= '0;
            ovp_left    <= '0;
            done_r      <= 1'b0;
            fail_r      <= 1'b0;
            fail_addr_r <= '0;
        end else begin
            if (take_start) begin
                mode_r      <= mode_i;
                done_r      <= 1'b0;
                fail_r      <= 1'b0;
                fail_addr_r <= '0;
            end
            if (take_byte) begin
                data_r    <= wr_data_i;
                skip_r    <= skip_in;
                tries     <= '0;
                ovp_phase <= 1'b0;
            end
            if (state == S_SETUP && tmr_exp) begin
                if (ovp_phase) ovp_left <= OVW'(tries) * OVW'(OVP_MULT);
                else           tries    <= tries + TRW'(1);
            end
            if (ovp_rearm) ovp_left <= ovp_left - OVW'(1);
            if (state == S_RECOVER && tmr_exp && vfy_match && mode_r && !skip_r)
                ovp_phase <= 1'b1;
            if (fail_now) begin
                fail_r      <= 1'b1;
                fail_addr_r <= prom_addr_o;
            end
            if (state == S_FINISH) done_r <= 1'b1;
        end
    end

    // Pin decode from state
    always_comb begin
        prom_wdata_o  = data_r;
        prom_wdrive_o = 1'b0;
        prom_vpp_en_o = 1'b0;
        prom_ce_n_o   = 1'b1;
        prom_oe_n_o   = 1'b1;
        wr_ready_o    = 1'b0;
        unique case (state)
            S_FETCH: wr_ready_o = 1'b1;
            S_SETUP, S_HOLD: begin
                prom_wdrive_o = 1'b1;
                prom_vpp_en_o = 1'b1;
            end
            S_PULSE, S_OVP: begin
                prom_wdrive_o = 1'b1;
                prom_vpp_en_o = 1'b1;
                prom_ce_n_o   = 1'b0;
            end
            S_READ: begin
                prom_ce_n_o = 1'b0;
                prom_oe_n_o = 1'b0;
            end
            default: ;
        endcase
    end

    assign busy_o      = (state != S_IDLE);
    assign done_o      = done_r;
    assign fail_o      = fail_r;
    assign fail_addr_o = fail_addr_r;

    // R3: a program pulse only happens with supply and data driven
    a_r3_pulse_has_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (!prom_ce_n_o && prom_oe_n_o) |-> (prom_vpp_en_o && prom_wdrive_o));

    // R3: address never moves while chip enable is low
    a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!prom_ce_n_o && !$past(prom_ce_n_o)) |-> $stable(prom_addr_o));

    // R8: reads happen with supply and driver off
    a_r8_read_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        !prom_oe_n_o |-> (!prom_vpp_en_o && !prom_wdrive_o && !prom_ce_n_o));

    // R7: supply still on in the first cycle after a pulse ends
    a_r7_supply_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prom_ce_n_o) && $past(prom_oe_n_o)) |-> prom_vpp_en_o);

    // R2: bytes are requested only during a run
    a_r2_ready_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready_o |-> busy_o);

    // R5: retry count never exceeds the limit
    a_r5_tries_cap: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRW'(MAX_TRIES));

    // R10: fail flag holds until a new start
    a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o);

    // R11: done is only shown while idle
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: tb/sim_eprom_burn_seq.sv
module sim_eprom_burn_seq;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NW = 1 << AW;
    // 1 MHz design clock parameter: one cycle per 1000 ns
    localparam int CLK_HZ   = 1_000_000;
    localparam int SETUP_NS = 2_000;
    localparam int HOLD_NS  = 1_500;
    localparam int LONG_NS  = 11_500;
    localparam int SHORT_NS = 2_100;
    localparam int VFY_NS   = 1_500;
    localparam int FLOAT_NS = 130;
    localparam int MAXT     = 4;
    localparam int MULT     = 3;
    localparam int SETUP_C = (SETUP_NS + 999) / 1000;
    localparam int HOLD_C  = (HOLD_NS  + 999) / 1000;
    localparam int LONG_C  = (LONG_NS  + 999) / 1000;
    localparam int SHORT_C = (SHORT_NS + 999) / 1000;
    localparam int VFY_C   = (VFY_NS   + 999) / 1000;
    localparam int FLOAT_C = (FLOAT_NS + 999) / 1000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, mode_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0;
    logic [AW:0]   word_count_i = '0;
    logic wr_valid_i, wr_ready_o;
    logic [DW-1:0] wr_data_i, prom_wdata_o, prom_din_i;
    logic [AW-1:0] prom_addr_o, fail_addr_o;
    logic prom_wdrive_o, prom_ce_n_o, prom_oe_n_o, prom_vpp_en_o;
    logic busy_o, done_o, fail_o;

    always #10 clk = ~clk;

    eprom_burn_seq #(
        .AW(AW), .DW(DW), .CLK_HZ(CLK_HZ), .SETUP_NS(SETUP_NS), .HOLD_NS(HOLD_NS),
        .LONG_NS(LONG_NS), .SHORT_NS(SHORT_NS), .VFY_NS(VFY_NS), .FLOAT_NS(FLOAT_NS),
        .MAX_TRIES(MAXT), .OVP_MULT(MULT)
    ) u0 (.*);

    int n_chk = 0, n_err = 0, cycles = 0;

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    task automatic chk_ge(input string tag, input int act, input int minv);
        n_chk++;
        if (act < minv) begin
            n_err++;
            $display("FAIL %s act=%0d exp>=%0d", tag, act, minv);
        end
    endtask

    // Byte source
    logic [DW-1:0] src [8];
    int src_n = 0, t0 = 0, taken = 0, k;
    assign k          = taken - t0;
    assign wr_valid_i = (k < src_n);
    assign wr_data_i  = (k < src_n) ? src[k[2:0]] : '0;

    // PROM model
    logic [DW-1:0] mem [NW];
    logic [DW-1:0] init_mem [NW];
    int need [NW];
    int pcnt [NW], first_len [NW], last_len [NW];
    int rd_cnt = 0;
    assign prom_din_i = (!prom_ce_n_o && !prom_oe_n_o && rd_cnt >= VFY_C - 1)
                        ? mem[prom_addr_o] : ~mem[prom_addr_o];

    logic [AW+DW+1:0] sig, prev_sig;
    logic prev_ce = 1'b1, prev_oe = 1'b1;
    int stab = 0, plen = 0, hcnt = 0, off_cnt = 0;
    bit htrack = 1'b0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (wr_valid_i && wr_ready_o) taken <= taken + 1;
            rd_cnt <= (!prom_ce_n_o && !prom_oe_n_o) ? rd_cnt + 1 : 0;
            sig = {prom_addr_o, prom_wdata_o, prom_wdrive_o, prom_vpp_en_o};
            if (sig == prev_sig) stab++; else stab = 0;
            off_cnt = prom_wdrive_o ? 0 : off_cnt + 1;
            if (htrack) begin
                if (stab == 0) begin
                    chk_ge("R7 hold cycles", hcnt, HOLD_C);
                    htrack = 1'b0;
                end else hcnt++;
            end
            if (!prom_ce_n_o && prom_oe_n_o) begin
                if (prev_ce) chk_ge("R3 setup cycles", stab, SETUP_C);
                plen++;
            end
            if (prom_ce_n_o && !prev_ce && prev_oe) begin
                pcnt[prom_addr_o]++;
                if (pcnt[prom_addr_o] == 1) first_len[prom_addr_o] = plen;
                last_len[prom_addr_o] = plen;
                if (pcnt[prom_addr_o] >= need[prom_addr_o])
                    mem[prom_addr_o] = mem[prom_addr_o] & prom_wdata_o;
                plen = 0;
                htrack = 1'b1;
                hcnt = 1;
            end
            if (!prom_oe_n_o && prev_oe) chk_ge("R8 release cycles", off_cnt, FLOAT_C + 1);
            prev_ce  = prom_ce_n_o;
            prev_oe  = prom_oe_n_o;
            prev_sig = sig;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150_000) begin
            n_chk++; n_err++;
            $display("FAIL R11 watchdog act=%0d exp<150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic clear_model();
        for (int a = 0; a < NW; a++) begin
            mem[a] = 8'hFF; need[a] = 1; pcnt[a] = 0; first_len[a] = 0; last_len[a] = 0;
        end
    endtask

    task automatic run_job(input bit md, input int base, input int cnt, input bit poke);
        for (int a = 0; a < NW; a++) init_mem[a] = mem[a];
        t0 = taken;
        src_n = cnt;
        @(negedge clk);
        base_addr_i = AW'(base); word_count_i = (AW+1)'(cnt); mode_i = md; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            base_addr_i = '0; word_count_i = 1; mode_i = ~md; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Expected outcome from the requirements, word by word
    task automatic check_job(input bit md, input int base, input int cnt, input string tag);
        bit failed = 1'b0;
        int fa = 0, used = cnt;
        for (int i = 0; i < cnt; i++) begin
            int a = (base + i) % NW;
            logic [DW-1:0] d = src[i];
            int ep; bit ok;
            if (failed) begin
                chk({tag, " R10 no pulse after fail"}, pcnt[a], 0);
                continue;
            end
            if (d == 8'hFF) begin ep = 0; ok = (init_mem[a] == 8'hFF); end
            else if (!md)   begin ep = 1; ok = (need[a] <= 1); end
            else if (need[a] <= MAXT) begin ep = need[a] + 1; ok = 1'b1; end
            else begin ep = MAXT; ok = 1'b0; end
            chk({tag, " pulse count"}, pcnt[a], ep);
            if (ok && d != 8'hFF) begin
                chk({tag, " R2 stored byte"}, int'(mem[a]), int'(d & init_mem[a]));
                if (!md) begin
                    chk({tag, " R4 R12 long pulse"}, last_len[a], LONG_C);
                end else begin
                    chk({tag, " R5 short pulse"}, first_len[a], SHORT_C);
                    chk({tag, " R6 over-program"}, last_len[a], MULT * need[a] * SHORT_C);
                end
            end else if (!md && !ok && d != 8'hFF) begin
                chk({tag, " R4 single pulse len"}, last_len[a], LONG_C);
            end else if (md && !ok && d != 8'hFF) begin
                chk({tag, " R5 retry pulse len"}, last_len[a], SHORT_C);
            end
            if (!ok) begin failed = 1'b1; fa = a; used = i + 1; end
        end
        chk({tag, " R10 R11 fail flag"}, int'(fail_o), int'(failed));
        if (failed) chk({tag, " R10 fail addr"}, int'(fail_addr_o), fa);
        chk({tag, " R11 done"}, int'(done_o), 1);
        chk({tag, " R11 busy low"}, int'(busy_o), 0);
        chk({tag, " R2 bytes taken"}, taken - t0, used);
    endtask

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ce_n", int'(prom_ce_n_o), 1);
        chk("R1 oe_n", int'(prom_oe_n_o), 1);
        chk("R1 vpp", int'(prom_vpp_en_o), 0);
        chk("R1 wdrive", int'(prom_wdrive_o), 0);
        chk("R1 ready", int'(wr_ready_o), 0);
        chk("R1 busy/done/fail", int'({busy_o, done_o, fail_o}), 0);

        // Job A: single pulse, wraps address, includes an all-ones byte (R4 R9 R2)
        clear_model();
        src[0] = 8'h3C; src[1] = 8'hFF; src[2] = 8'h00; src[3] = 8'hA5;
        run_job(1'b0, 14, 4, 1'b0);
        check_job(1'b0, 14, 4, "jobA");

        // Job B: incremental profile with retries, poke start mid-run (R5 R6 R13)
        clear_model();
        need[4] = 1; need[5] = 3;
        src[0] = 8'h12; src[1] = 8'h7F; src[2] = 8'hFF;
        run_job(1'b1, 4, 3, 1'b1);
        check_job(1'b1, 4, 3, "jobB R13");
        chk("R13 address 0 untouched", pcnt[0], 0);

        // Job C: retry limit reached (R5 R10)
        clear_model();
        need[8] = 2; need[9] = MAXT + 1; need[10] = 1;
        src[0] = 8'h55; src[1] = 8'h0F; src[2] = 8'hF0;
        run_job(1'b1, 8, 3, 1'b0);
        check_job(1'b1, 8, 3, "jobC");

        // Job D: single pulse insufficient (R4 R10)
        clear_model();
        need[3] = 2;
        src[0] = 8'h01; src[1] = 8'h02;
        run_job(1'b0, 3, 2, 1'b0);
        check_job(1'b0, 3, 2, "jobD");

        // Job E: all-ones byte over a programmed cell (R9)
        clear_model();
        mem[6] = 8'hFE;
        src[0] = 8'hFF; src[1] = 8'h00;
        run_job(1'b0, 6, 2, 1'b0);
        check_job(1'b0, 6, 2, "jobE R9");

        // Job F: zero count (R11)
        clear_model();
        run_job(1'b1, 0, 0, 1'b0);
        check_job(1'b1, 0, 0, "jobF");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule